// File: doc/BRIEF.md
# Floating-Point Status, Exception and Trap Unit

This block holds the floating-point status state of a core and updates it each time a floating-point operation finishes. The arithmetic datapath signals the start of an operation together with its kind. While the operation runs it reports exception flags, and they are collected in an accumulator that the start strobe clears. At completion the collected flags become the current-exception field of the status. The flags are then compared against the trap-enable mask. If any flag is enabled, the unit raises a one-cycle trap pulse with a priority-encoded trap code and leaves the accrued field alone. Otherwise the flags are merged into the accrued field. A compare operation writes its two-bit condition code only when none of its flags is enabled.

The stored rounding direction and precision go to the datapath. The unit also tells the datapath which rounding to use for the operation in flight: a float-to-integer conversion always rounds toward zero. It also tells the datapath whether the compare in flight is the signalling variant. Operation kinds that the unit does not recognise are answered with an "unimplemented" result and leave the status untouched.

Completion uses a valid/ready handshake. A completion is taken only on a cycle where `done_valid` and `done_ready` are both high. The unit drops `done_ready` for the single cycle in which it presents a response, and for any cycle in which software writes the configuration, so at most one completion is taken every two cycles. The producer must hold `done_valid`, `exc_flags` and `cmp_code` steady until it is accepted.

Top module: `fpst_unit`

## Requirements
- R1: `op_start` clears the exception accumulator. While `exc_valid` is high, including the cycle of an accepted completion, `exc_flags` is ORed into the accumulator. Flags seen before `op_start` are lost. On completion, `cexc` is written with the accumulated flags. Bit positions in all exception fields are: invalid 4, overflow 3, underflow 2, divide-by-zero 1, inexact 0.
- R2: One cycle after an accepted completion, `resp_valid` is high for one cycle. If `cexc & tem` is nonzero, `trap_pulse` is high in that same cycle and `result_type` is 1 (ieee). Otherwise `trap_pulse` stays low and `result_type` is 0 (none).
- R3: `trap_code` selects the enabled exception of highest priority: invalid gives 1, overflow 2, underflow 3, divide-by-zero 4, inexact 5. The code is 0 whenever `trap_pulse` is low.
- R4: A completion that traps leaves `aexc` unchanged but still writes `cexc`.
- R5: A completion that does not trap ORs its exceptions into `aexc`. Apart from a configuration write, `aexc` never loses a bit.
- R6: For kinds 1 (quiet compare) and 2 (signalling compare), `fcc` takes `cmp_code` only when the operation has no enabled exception. No other kind changes `fcc`.
- R7: `dp_cmp_signal` is high exactly while the kind latched at the last `op_start` is 2.
- R8: While the latched kind is 3 (float-to-integer), `dp_rnd` is 1 (toward zero) whatever `rnd` holds. For all other kinds, `dp_rnd` equals `rnd`. Rounding codes are: 0 nearest, 1 zero, 2 up, 3 down.
- R9: Kinds 4 to 7 complete with `result_type` 2 (unimplemented) and no trap, and leave `cexc`, `aexc` and `fcc` unchanged.
- R10: `done_ready` is low in the cycle in which `resp_valid` is high and in any cycle in which `cfg_we` is high, and high otherwise.
- R11: Reset clears all status fields and outputs to zero. `cfg_we` loads `tem`, `rnd`, `prec` and `aexc` from the `cfg_*` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tem | input | 5 | Trap-enable mask to load |
| cfg_rnd | input | 2 | Rounding direction to load |
| cfg_prec | input | 2 | Rounding precision to load |
| cfg_aexc | input | 5 | Accrued field value to load |
| op_start | input | 1 | Start of an operation; clears the accumulator |
| op_kind | input | 3 | Operation kind, latched on op_start |
| exc_valid | input | 1 | exc_flags carries raised exceptions |
| exc_flags | input | 5 | Exceptions raised by the running operation |
| cmp_code | input | 2 | Condition code produced by a compare |
| done_valid | input | 1 | Operation completion offered |
| done_ready | output | 1 | Completion can be accepted |
| dp_rnd | output | 2 | Rounding to use for the operation in flight |
| dp_prec | output | 2 | Rounding precision to the datapath |
| dp_cmp_signal | output | 1 | Compare in flight is the signalling variant |
| resp_valid | output | 1 | Response for the accepted completion |
| result_type | output | 2 | 0 none, 1 ieee, 2 unimplemented |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_code | output | 3 | Priority-encoded trap cause, 0 none |
| cexc | output | 5 | Current-exception field |
| aexc | output | 5 | Accrued-exception field |
| fcc | output | 2 | Floating condition code |
| tem | output | 5 | Trap-enable mask |
| rnd | output | 2 | Stored rounding direction |
| prec | output | 2 | Stored rounding precision |

## Verification
Some properties are checked by assertions on every cycle. A trap always carries a nonzero code and an ieee result, and no code appears without a trap. A trap never disturbs the accrued field, and outside configuration writes that field only gains bits. The ready line falls during a response and during configuration writes. An unimplemented kind never traps and never moves the current field. Other behaviour can only be shown by the bench's scenarios, which sweep every exception pattern against every trap mask: the exact trap-code priority, the merged accrued value, the gating of the condition code, the clearing of stale flags at start, and the forced toward-zero rounding.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int EXC_W  = 5;
  localparam int CODE_W = $clog2(EXC_W + 1);
  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] KIND_ARITH = 3'd0;
  localparam logic [KIND_W-1:0] KIND_CMPQ  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_CMPS  = 3'd2;
  localparam logic [KIND_W-1:0] KIND_TOINT = 3'd3;
  localparam logic [KIND_W-1:0] KIND_LAST  = 3'd3;

  localparam logic [1:0] RND_ZERO = 2'd1;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_IEEE  = 2'd1,
    RES_UNIMP = 2'd2
  } res_t;
endpackage

// File: rtl/fpst_trap_sel.sv
module fpst_trap_sel #(
  parameter int W      = 5,
  parameter int CODE_W = $clog2(W + 1)
) (
  input  logic [W-1:0]      hit,
  output logic [CODE_W-1:0] code
);
  // Highest bit has highest priority and gets code 1; bit 0 gets code W.
  always_comb begin
    code = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) code = CODE_W'(W - i);
    end
  end
endmodule

// File: rtl/fpst_acc.sv
module fpst_acc #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         add_en,
  input  logic [W-1:0] add,
  output logic [W-1:0] total
);
  logic [W-1:0] acc_q;
  logic [W-1:0] add_m;

  assign add_m = add_en ? add : '0;
  assign total = acc_q | add_m;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= acc_q | add_m;
  end
endmodule

// File: rtl/fpst_status.sv
module fpst_status #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_tem,
  input  logic [1:0]   cfg_rnd,
  input  logic [1:0]   cfg_prec,
  input  logic [W-1:0] cfg_aexc,
  input  logic         upd_en,
  input  logic [W-1:0] new_cexc,
  input  logic         merge_en,
  input  logic         fcc_we,
  input  logic [1:0]   fcc_new,
  output logic [W-1:0] tem,
  output logic [1:0]   rnd,
  output logic [1:0]   prec,
  output logic [W-1:0] aexc,
  output logic [W-1:0] cexc,
  output logic [1:0]   fcc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tem  <= '0;
      rnd  <= '0;
      prec <= '0;
      aexc <= '0;
      cexc <= '0;
      fcc  <= '0;
    end else begin
      if (cfg_we) begin
        tem  <= cfg_tem;
        rnd  <= cfg_rnd;
        prec <= cfg_prec;
        aexc <= cfg_aexc;
      end else if (merge_en) begin
        aexc <= aexc | new_cexc;
      end
      if (upd_en) cexc <= new_cexc;
      if (fcc_we) fcc  <= fcc_new;
    end
  end
endmodule

// File: rtl/fpst_unit.sv
module fpst_unit
  import fpst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [4:0]  cfg_tem,
  input  logic [1:0]  cfg_rnd,
  input  logic [1:0]  cfg_prec,
  input  logic [4:0]  cfg_aexc,
  input  logic        op_start,
  input  logic [2:0]  op_kind,
  input  logic        exc_valid,
  input  logic [4:0]  exc_flags,
  input  logic [1:0]  cmp_code,
  input  logic        done_valid,
  output logic        done_ready,
  output logic [1:0]  dp_rnd,
  output logic [1:0]  dp_prec,
  output logic        dp_cmp_signal,
  output logic        resp_valid,
  output logic [1:0]  result_type,
  output logic        trap_pulse,
  output logic [2:0]  trap_code,
  output logic [4:0]  cexc,
  output logic [4:0]  aexc,
  output logic [1:0]  fcc,
  output logic [4:0]  tem,
  output logic [1:0]  rnd,
  output logic [1:0]  prec
);
  logic [KIND_W-1:0] kind_q;
  logic [EXC_W-1:0]  flags_total;
  logic [EXC_W-1:0]  enabled_hit;
  logic [CODE_W-1:0] sel_code;
  logic              accept;
  logic              known;
  logic              is_cmp;
  logic              take_trap;
  res_t              res_d;

  always_ff @(posedge clk) begin
    if (!rst_n)        kind_q <= KIND_ARITH;
    else if (op_start) kind_q <= op_kind;
  end

  assign known  = (kind_q <= KIND_LAST);
  assign is_cmp = (kind_q == KIND_CMPQ) || (kind_q == KIND_CMPS);

  assign done_ready = !resp_valid && !cfg_we;
  assign accept     = done_valid && done_ready;

  fpst_acc #(.W(EXC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (op_start),
    .add_en (exc_valid),
    .add    (exc_flags),
    .total  (flags_total)
  );

  assign enabled_hit = flags_total & tem;
  assign take_trap   = known && (|enabled_hit);

  fpst_trap_sel #(.W(EXC_W), .CODE_W(CODE_W)) u_sel (
    .hit  (enabled_hit),
    .code (sel_code)
  );

  fpst_status #(.W(EXC_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_tem  (cfg_tem),
    .cfg_rnd  (cfg_rnd),
    .cfg_prec (cfg_prec),
    .cfg_aexc (cfg_aexc),
    .upd_en   (accept && known),
    .new_cexc (flags_total),
    .merge_en (accept && known && !take_trap),
    .fcc_we   (accept && known && is_cmp && !(|enabled_hit)),
    .fcc_new  (cmp_code),
    .tem      (tem),
    .rnd      (rnd),
    .prec     (prec),
    .aexc     (aexc),
    .cexc     (cexc),
    .fcc      (fcc)
  );

  always_comb begin
    if (!known)         res_d = RES_UNIMP;
    else if (take_trap) res_d = RES_IEEE;
    else                res_d = RES_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      trap_pulse  <= 1'b0;
      trap_code   <= '0;
      result_type <= RES_NONE;
    end else begin
      resp_valid  <= accept;
      trap_pulse  <= accept && take_trap;
      trap_code   <= (accept && take_trap) ? sel_code : '0;
      result_type <= accept ? res_d : RES_NONE;
    end
  end

  assign dp_rnd        = (kind_q == KIND_TOINT) ? RND_ZERO : rnd;
  assign dp_prec       = prec;
  assign dp_cmp_signal = (kind_q == KIND_CMPS);
endmodule

// File: rtl/fpst_unit_chk.sv
module fpst_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       done_ready,
  input logic       resp_valid,
  input logic [1:0] result_type,
  input logic       trap_pulse,
  input logic [2:0] trap_code,
  input logic [4:0] cexc,
  input logic [4:0] aexc
);
  AST_TRAP_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> trap_code != 3'd0); // R3
  AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_pulse |-> trap_code == 3'd0); // R3
  AST_TRAP_IS_IEEE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (resp_valid && result_type == 2'd1)); // R2
  AST_TRAP_KEEPS_AEXC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> aexc == $past(aexc)); // R4
  AST_AEXC_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($past(aexc) & ~aexc) == 5'd0); // R5
  AST_RESP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !done_ready); // R10
  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !done_ready); // R10
  AST_UNIMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && result_type == 2'd2) |-> (!trap_pulse && cexc == $past(cexc))); // R9
endmodule

bind fpst_unit fpst_unit_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .done_ready  (done_ready),
  .resp_valid  (resp_valid),
  .result_type (result_type),
  .trap_pulse  (trap_pulse),
  .trap_code   (trap_code),
  .cexc        (cexc),
  .aexc        (aexc)
);

// File: tb/test_fpst_unit.sv
module test_fpst_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_tem = '0;
  logic [1:0] cfg_rnd = '0;
  logic [1:0] cfg_prec = '0;
  logic [4:0] cfg_aexc = '0;
  logic       op_start = 1'b0;
  logic [2:0] op_kind = '0;
  logic       exc_valid = 1'b0;
  logic [4:0] exc_flags = '0;
  logic [1:0] cmp_code = '0;
  logic       done_valid = 1'b0;
  logic       done_ready;
  logic [1:0] dp_rnd, dp_prec, result_type, fcc, rnd, prec;
  logic       dp_cmp_signal, resp_valid, trap_pulse;
  logic [2:0] trap_code;
  logic [4:0] cexc, aexc, tem;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] m_aexc, m_cexc, m_tem;
  logic [1:0] m_fcc, m_rnd;

  always #10 clk = ~clk;

  fpst_unit i_fpst_unit (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] prio(input logic [4:0] h);
    if (h[4]) return 3'd1;
    if (h[3]) return 3'd2;
    if (h[2]) return 3'd3;
    if (h[1]) return 3'd4;
    if (h[0]) return 3'd5;
    return 3'd0;
  endfunction

  task automatic cfg(input logic [4:0] t, input logic [1:0] r, input logic [4:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tem = t; cfg_rnd = r; cfg_prec = 2'd2; cfg_aexc = a;
    done_valid = 1'b1;
    #1 chk({7'd0, done_ready}, 8'd0, "R10 ready low on cfg write");
    @(negedge clk);
    cfg_we = 1'b0; done_valid = 1'b0;
    m_tem = t; m_rnd = r; m_aexc = a;
    chk({7'd0, resp_valid}, 8'd0, "R10 no completion during cfg write");
    chk({1'b0, tem, rnd}, {1'b0, t, r}, "R11 cfg load tem/rnd");
    chk({6'd0, prec}, 8'd2, "R11 cfg load prec");
  endtask

  // Operation: junk flags before start, half of e mid-op, the rest on the done cycle
  task automatic run_op(input logic [2:0] k, input logic [4:0] e, input logic [1:0] cc);
    logic [4:0] hit;
    logic       known;
    @(negedge clk);
    exc_valid = 1'b1; exc_flags = ~e;
    @(negedge clk);
    exc_valid = 1'b0; op_start = 1'b1; op_kind = k;
    @(negedge clk);
    op_start = 1'b0;
    chk({6'd0, dp_rnd}, {6'd0, (k == 3'd3) ? 2'd1 : m_rnd}, "R8 datapath rounding");
    chk({7'd0, dp_cmp_signal}, {7'd0, k == 3'd2}, "R7 signalling flag");
    exc_valid = 1'b1; exc_flags = e & 5'b10101;
    @(negedge clk);
    exc_flags = e & 5'b01010; done_valid = 1'b1; cmp_code = cc;
    chk({7'd0, done_ready}, 8'd1, "R10 ready idle");
    @(negedge clk);
    done_valid = 1'b0; exc_valid = 1'b0;
    known = (k <= 3'd3);
    hit = e & m_tem;
    chk({7'd0, resp_valid}, 8'd1, "R2 response valid");
    chk({7'd0, done_ready}, 8'd0, "R10 ready low in response cycle");
    if (known) begin
      m_cexc = e;
      if (hit == 0) m_aexc = m_aexc | e;
      if ((k == 3'd1 || k == 3'd2) && hit == 0) m_fcc = cc;
    end
    chk({3'd0, cexc}, {3'd0, m_cexc}, known ? "R1 current field" : "R9 current field kept");
    chk({3'd0, aexc}, {3'd0, m_aexc}, (hit != 0) ? "R4 accrued kept" : "R5 accrued merge");
    chk({6'd0, fcc}, {6'd0, m_fcc}, "R6 condition code");
    chk({7'd0, trap_pulse}, {7'd0, known && hit != 0}, "R2 trap pulse");
    chk({5'd0, trap_code}, {5'd0, known ? prio(hit) : 3'd0}, "R3 trap code");
    chk({6'd0, result_type}, {6'd0, !known ? 2'd2 : (hit != 0 ? 2'd1 : 2'd0)}, "R2 R9 result type");
    @(negedge clk);
    chk({7'd0, resp_valid | trap_pulse}, 8'd0, "R2 single-cycle response");
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_aexc = '0; m_cexc = '0; m_tem = '0; m_fcc = '0; m_rnd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({3'd0, cexc}, 8'd0, "R11 reset cexc");
    chk({3'd0, aexc}, 8'd0, "R11 reset aexc");
    chk({1'b0, tem, fcc}, 8'd0, "R11 reset tem/fcc");
    chk({2'd0, resp_valid, trap_pulse, trap_code, 1'b0}, 8'd0, "R11 reset outputs");

    // Arithmetic kind: every exception pattern against every mask
    for (int t = 0; t < 32; t++) begin
      cfg(5'(t), 2'(t), 5'd0);
      for (int e = 0; e < 32; e++) run_op(3'd0, 5'(e), 2'd0);
    end
    // Compares, both variants, against a few masks
    for (int m = 0; m < 3; m++) begin
      cfg((m == 0) ? 5'h00 : (m == 1) ? 5'h10 : 5'h01, 2'd3, 5'd0);
      for (int e = 0; e < 32; e++) run_op(3'(1 + (e % 2)), 5'(e), 2'(e + m));
    end
    // Float-to-integer under every rounding setting
    for (int r = 0; r < 4; r++) begin
      cfg(5'h02, 2'(r), 5'h04);
      run_op(3'd3, 5'h01, 2'd1);
      run_op(3'd3, 5'h03, 2'd2);
    end
    // Unrecognised kinds leave status alone
    for (int k = 4; k < 8; k++) begin
      cfg(5'h1f, 2'd0, 5'h08);
      run_op(3'd1, 5'h00, 2'd3);
      run_op(3'(k), 5'h1f, 2'd0);
      run_op(3'(k), 5'h00, 2'd1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule